// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with 56-bit Accumulator

This block is the multiply-accumulate datapath of a small RISC core. It keeps a 56-bit signed accumulator and takes at most one operation per cycle on a valid/ready interface. Each operation carries a 4-bit opcode and two 32-bit operands. Eight multiply opcodes choose between two actions, overwriting the accumulator or adding to it, and between four operand slicings: halfword by halfword, or full word by halfword. Two rounding opcodes reduce the accumulator to a 16-bit or 32-bit field. A read-out opcode shifts the accumulator and returns a 32-bit window of it.

A separate opcode computes a full 32x32 signed product. It runs the same 32x16 signed array over several cycles and returns the low 32 bits of the product. The accumulator is left alone. While that sequence runs, the unit lowers ready and ignores anything offered to it.

All products are signed two's complement. Each is sign-extended to 56 bits, and accumulation wraps modulo 2^56. The binary point sits 16 bits above the accumulator LSB, so the halfword-by-halfword products are placed shifted left by 16.

Top module: `mac56_unit`

## Requirements
- R1: After reset the accumulator reads 0, `busy` and `res_valid` are low and `in_ready` is high.
- R2: Opcodes 1..4 overwrite the accumulator at the clock edge that accepts them. Each writes the sign-extended signed product of one operand slicing: 1 = a[31:16]*b[31:16] shifted left 16; 2 = a[15:0]*b[15:0] shifted left 16; 3 = a*b[31:16]; 4 = a*b[15:0].
- R3: Opcodes 5..8 use the same four slicings, in the same order, and add the product to the accumulator, wrapping modulo 2^56.
- R4: A multiply or multiply-accumulate opcode can be accepted on every cycle. Back-to-back operations each take effect in turn.
- R5: Opcode 10 (32-bit precision) adds 2^15 to the accumulator and clears bits [15:0]. It saturates the result to the range [-2^47, 2^47-2^16].
- R6: Opcode 9 (16-bit precision) adds 2^31 to the accumulator and clears bits [31:0]. It saturates the result to the range [-2^47, 2^47-2^32].
- R7: Opcode 11 returns bits [47:16] of the accumulator shifted left by b[1:0]. `res_valid` is high for the one cycle after acceptance, and the accumulator does not change.
- R8: Opcode 12 holds `busy` high for exactly 3 cycles after acceptance. When `busy` falls, `res_valid` pulses with the low 32 bits of the signed product a*b. The accumulator does not change.
- R9: While `busy` is high, `in_ready` is low and any offered operation is ignored.
- R10: Opcode 0 and the unused opcodes 13..15 leave the accumulator unchanged and produce no result.
- R11: `res_valid` is raised only by opcode 11 or by the completion of opcode 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 32 | First register operand |
| in_b | input | 32 | Second register operand (also the shift amount for read-out) |
| in_ready | output | 1 | Unit can accept an operation |
| busy | output | 1 | 32x32 multiply sequence in progress |
| res_valid | output | 1 | Result word valid |
| res_data | output | 32 | Read-out or 32x32 product word |
| acc_val | output | 56 | Current accumulator contents |

## Verification
The bench builds the unit with its default widths: 32-bit operands, 16-bit halves, a 56-bit accumulator, a 2-bit shift field and saturation enabled. With these values, 512 back-to-back accumulations of 2^46 are enough to reach the 2^55 wrap point. A sixteen-fold sum of 2^44 passes the 2^47 saturation limit from above, and the wrapped -2^55 value tests the limit from below. All four shift amounts of the read-out window can be tried, and the 32x32 multiply can be driven with extreme signed operands such as 0x80000000 squared.

// File: rtl/mac56_pkg.sv
package mac56_pkg;

   typedef enum logic [3:0] {
      OP_NOP    = 4'd0,
      OP_MUL_HH = 4'd1,
      OP_MUL_LL = 4'd2,
      OP_MUL_WH = 4'd3,
      OP_MUL_WL = 4'd4,
      OP_MAC_HH = 4'd5,
      OP_MAC_LL = 4'd6,
      OP_MAC_WH = 4'd7,
      OP_MAC_WL = 4'd8,
      OP_RND16  = 4'd9,
      OP_RND32  = 4'd10,
      OP_RDSH   = 4'd11,
      OP_MUL32  = 4'd12
   } mac_op_e;

   typedef enum logic [1:0] {
      SEL_HH = 2'd0,
      SEL_LL = 2'd1,
      SEL_WH = 2'd2,
      SEL_WL = 2'd3
   } slice_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LO   = 2'd1,
      SQ_HI   = 2'd2,
      SQ_FIN  = 2'd3
   } seq_e;

endpackage

// File: rtl/mac56_opsel.sv
// Builds the signed operands of the shared array from the slice mode,
// or from the multi-cycle sequencer phase when that is running.
module mac56_opsel import mac56_pkg::*; #(
   parameter int OP_W   = 32,
   parameter int HALF_W = 16
) (
   input  slice_e                   mode,
   input  logic                     seq_en,
   input  logic                     seq_hi,
   input  logic [OP_W-1:0]          a,
   input  logic [OP_W-1:0]          b,
   output logic signed [OP_W:0]     x,
   output logic signed [HALF_W:0]   y
);
   localparam int XPAD = OP_W + 1 - HALF_W;

   logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
   logic [OP_W:0]     a_full, a_hi_x, a_lo_x;
   logic [HALF_W:0]   b_hi_s, b_lo_s, b_lo_z;

   assign a_hi   = a[OP_W-1:HALF_W];
   assign a_lo   = a[HALF_W-1:0];
   assign b_hi   = b[OP_W-1:HALF_W];
   assign b_lo   = b[HALF_W-1:0];
   assign a_full = {a[OP_W-1], a};
   assign a_hi_x = {{XPAD{a_hi[HALF_W-1]}}, a_hi};
   assign a_lo_x = {{XPAD{a_lo[HALF_W-1]}}, a_lo};
   assign b_hi_s = {b_hi[HALF_W-1], b_hi};
   assign b_lo_s = {b_lo[HALF_W-1], b_lo};
   assign b_lo_z = {1'b0, b_lo};

   always_comb begin
      if (seq_en) begin
         x = a_full;
         y = seq_hi ? b_hi_s : b_lo_z;
      end else begin
         unique case (mode)
            SEL_HH:  begin x = a_hi_x; y = b_hi_s; end
            SEL_LL:  begin x = a_lo_x; y = b_lo_s; end
            SEL_WH:  begin x = a_full; y = b_hi_s; end
            default: begin x = a_full; y = b_lo_s; end
         endcase
      end
   end
endmodule

// File: rtl/mac56_array.sv
// Single signed (OP_W+1) x (HALF_W+1) multiplier array.
module mac56_array #(
   parameter int OP_W   = 32,
   parameter int HALF_W = 16,
   localparam int P_W   = OP_W + HALF_W + 2
) (
   input  logic signed [OP_W:0]   x,
   input  logic signed [HALF_W:0] y,
   output logic signed [P_W-1:0]  p
);
   logic signed [P_W-1:0] xe, ye;

   assign xe = P_W'(x);
   assign ye = P_W'(y);
   assign p  = xe * ye;
endmodule

// File: rtl/mac56_round.sv
// Round-half-up of the accumulator at bit FRAC, with optional saturation
// to the sign-extended LIM_W-bit range.
module mac56_round #(
   parameter int ACC_W  = 56,
   parameter int FRAC   = 16,
   parameter int LIM_W  = 48,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [ACC_W-1:0] acc,
   output logic [ACC_W-1:0] res
);
   localparam int S_W = ACC_W + 1;
   localparam logic signed [S_W-1:0] HALF = S_W'(1) << (FRAC - 1);
   localparam logic signed [S_W-1:0] MAXV = (S_W'(1) << (LIM_W - 1)) - (S_W'(1) << FRAC);
   localparam logic signed [S_W-1:0] MINV = -(S_W'(1) << (LIM_W - 1));

   if (FRAC < 1 || FRAC >= LIM_W || LIM_W > ACC_W) begin : g_bad_cfg
      $error("mac56_round: FRAC/LIM_W out of range");
   end

   logic signed [S_W-1:0] sum;
   logic [ACC_W-1:0]      cleared;

   assign sum     = $signed({acc[ACC_W-1], acc}) + HALF;
   assign cleared = {sum[ACC_W-1:FRAC], {FRAC{1'b0}}};

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (sum > MAXV)      res = MAXV[ACC_W-1:0];
         else if (sum < MINV) res = MINV[ACC_W-1:0];
         else                 res = cleared;
      end
   end else begin : g_wrap
      assign res = cleared;
   end
endmodule

// File: rtl/mac56_mul32_seq.sv
// Three-cycle 32x32 signed multiply on the shared 32x16 array:
// low-half partial, high-half partial, then combine.
module mac56_mul32_seq import mac56_pkg::*; #(
   parameter int OP_W   = 32,
   parameter int HALF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OP_W-1:0]  a_in,
   input  logic [OP_W-1:0]  b_in,
   input  logic [OP_W-1:0]  prod_lo,
   output logic             busy,
   output logic             hi_phase,
   output logic [OP_W-1:0]  op_a,
   output logic [OP_W-1:0]  op_b,
   output logic             done,
   output logic [OP_W-1:0]  result
);
   seq_e              st_q;
   logic [OP_W-1:0]   part_lo_q;
   logic [HALF_W-1:0] part_hi_q;

   assign busy     = (st_q != SQ_IDLE);
   assign hi_phase = (st_q == SQ_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         op_a      <= '0;
         op_b      <= '0;
         part_lo_q <= '0;
         part_hi_q <= '0;
         done      <= 1'b0;
         result    <= '0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            SQ_IDLE: if (start) begin
               op_a <= a_in;
               op_b <= b_in;
               st_q <= SQ_LO;
            end
            SQ_LO: begin
               part_lo_q <= prod_lo;
               st_q      <= SQ_HI;
            end
            SQ_HI: begin
               part_hi_q <= prod_lo[HALF_W-1:0];
               st_q      <= SQ_FIN;
            end
            default: begin
               result <= part_lo_q + {part_hi_q, {(OP_W-HALF_W){1'b0}}};
               done   <= 1'b1;
               st_q   <= SQ_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/mac56_unit.sv
module mac56_unit import mac56_pkg::*; #(
   parameter int OP_W   = 32,
   parameter int HALF_W = 16,
   parameter int ACC_W  = 56,
   parameter int SH_W   = 2,
   parameter bit SAT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [OP_W-1:0]   in_a,
   input  logic [OP_W-1:0]   in_b,
   output logic              in_ready,
   output logic              busy,
   output logic              res_valid,
   output logic [OP_W-1:0]   res_data,
   output logic [ACC_W-1:0]  acc_val
);
   localparam int P_W   = OP_W + HALF_W + 2;
   localparam int WIN_H = OP_W + HALF_W - 1;
   localparam int LIM_W = OP_W + HALF_W;

   if (OP_W != 2 * HALF_W) begin : g_bad_half
      $error("mac56_unit: OP_W must be twice HALF_W");
   end
   if (ACC_W < P_W) begin : g_bad_acc
      $error("mac56_unit: ACC_W too narrow for the array product");
   end
   if (SH_W < 1 || (1 << SH_W) > HALF_W) begin : g_bad_sh
      $error("mac56_unit: SH_W out of range");
   end

   mac_op_e           op;
   logic              accept;
   slice_e            mode;
   logic              is_mul, is_mac;
   logic [ACC_W-1:0]  acc_q, acc_nxt;

   assign op       = mac_op_e'(in_op);
   assign in_ready = ~busy;
   assign accept   = in_valid & in_ready;

   always_comb begin
      is_mul = 1'b0;
      is_mac = 1'b0;
      mode   = SEL_HH;
      unique case (op)
         OP_MUL_HH: begin is_mul = 1'b1; mode = SEL_HH; end
         OP_MUL_LL: begin is_mul = 1'b1; mode = SEL_LL; end
         OP_MUL_WH: begin is_mul = 1'b1; mode = SEL_WH; end
         OP_MUL_WL: begin is_mul = 1'b1; mode = SEL_WL; end
         OP_MAC_HH: begin is_mac = 1'b1; mode = SEL_HH; end
         OP_MAC_LL: begin is_mac = 1'b1; mode = SEL_LL; end
         OP_MAC_WH: begin is_mac = 1'b1; mode = SEL_WH; end
         OP_MAC_WL: begin is_mac = 1'b1; mode = SEL_WL; end
         default:   ;
      endcase
   end

   // ---- shared array and its two users ----
   logic                   seq_hi, seq_done;
   logic [OP_W-1:0]        seq_a, seq_b, seq_res;
   logic [OP_W-1:0]        arr_a, arr_b;
   logic signed [OP_W:0]   arr_x;
   logic signed [HALF_W:0] arr_y;
   logic signed [P_W-1:0]  prod;

   assign arr_a = busy ? seq_a : in_a;
   assign arr_b = busy ? seq_b : in_b;

   mac56_opsel #(.OP_W(OP_W), .HALF_W(HALF_W)) u_opsel (
      .mode   (mode),
      .seq_en (busy),
      .seq_hi (seq_hi),
      .a      (arr_a),
      .b      (arr_b),
      .x      (arr_x),
      .y      (arr_y)
   );

   mac56_array #(.OP_W(OP_W), .HALF_W(HALF_W)) u_array (
      .x (arr_x),
      .y (arr_y),
      .p (prod)
   );

   mac56_mul32_seq #(.OP_W(OP_W), .HALF_W(HALF_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept && (op == OP_MUL32)),
      .a_in     (in_a),
      .b_in     (in_b),
      .prod_lo  (prod[OP_W-1:0]),
      .busy     (busy),
      .hi_phase (seq_hi),
      .op_a     (seq_a),
      .op_b     (seq_b),
      .done     (seq_done),
      .result   (seq_res)
   );

   // ---- product placement ----
   logic [ACC_W-1:0] prod_ext, placed;
   assign prod_ext = {{(ACC_W-P_W){prod[P_W-1]}}, prod};
   assign placed   = (mode == SEL_HH || mode == SEL_LL) ? (prod_ext << HALF_W) : prod_ext;

   // ---- rounding at two precisions ----
   logic [ACC_W-1:0] rnd_hp, rnd_lp;

   mac56_round #(.ACC_W(ACC_W), .FRAC(HALF_W), .LIM_W(LIM_W), .SAT_EN(SAT_EN)) u_rnd_word (
      .acc (acc_q),
      .res (rnd_hp)
   );

   mac56_round #(.ACC_W(ACC_W), .FRAC(OP_W), .LIM_W(LIM_W), .SAT_EN(SAT_EN)) u_rnd_half (
      .acc (acc_q),
      .res (rnd_lp)
   );

   // ---- aligned read-out window ----
   logic [ACC_W-1:0] shifted;
   assign shifted = acc_q << in_b[SH_W-1:0];

   always_comb begin
      acc_nxt = acc_q;
      if (accept) begin
         if (is_mul)               acc_nxt = placed;
         else if (is_mac)          acc_nxt = acc_q + placed;
         else if (op == OP_RND32)  acc_nxt = rnd_hp;
         else if (op == OP_RND16)  acc_nxt = rnd_lp;
      end
   end

   logic            rd_valid_q;
   logic [OP_W-1:0] rd_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         acc_q      <= acc_nxt;
         rd_valid_q <= accept && (op == OP_RDSH);
         if (accept && (op == OP_RDSH)) rd_data_q <= shifted[WIN_H:HALF_W];
      end
   end

   assign acc_val   = acc_q;
   assign res_valid = rd_valid_q | seq_done;
   assign res_data  = seq_done ? seq_res : rd_data_q;
endmodule

// File: rtl/mac56_unit_chk.sv
module mac56_unit_chk #(
   parameter int ACC_W = 56
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [3:0]       in_op,
   input logic             in_ready,
   input logic             busy,
   input logic             res_valid,
   input logic [ACC_W-1:0] acc_val
);
   a_r9_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ready);

   a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> in_ready);

   a_r8_three_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy ##1 busy ##1 !busy);

   a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(acc_val));

   a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> res_valid);

   a_r7_read_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op == 4'd11) |=> $stable(acc_val));

   a_r11_result_source: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(busy) || $past(in_valid && in_ready && in_op == 4'd11)));
endmodule

bind mac56_unit mac56_unit_chk #(.ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_ready  (in_ready),
   .busy      (busy),
   .res_valid (res_valid),
   .acc_val   (acc_val)
);

// File: tb/test_mac56_unit.sv
`timescale 1ns/1ps
module test_mac56_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_op = 4'd0;
   logic [31:0] in_a = '0, in_b = '0;
   logic        in_ready, busy, res_valid;
   logic [31:0] res_data;
   logic [55:0] acc_val;

   always #4 clk = ~clk;

   mac56_unit i_mac56_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .in_ready(in_ready), .busy(busy),
      .res_valid(res_valid), .res_data(res_data), .acc_val(acc_val)
   );

   int checks = 0;
   int errors = 0;

   typedef struct { logic [31:0] data; string req; } exp_t;
   exp_t exp_q[$];
   logic [55:0] exp_acc = '0;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---- reference model ----
   function automatic logic [55:0] mprod(logic [3:0] op, logic [31:0] a, logic [31:0] b);
      longint p;
      case ((op - 4'd1) % 4)
         0: p = (longint'($signed(a[31:16])) * longint'($signed(b[31:16]))) <<< 16;
         1: p = (longint'($signed(a[15:0]))  * longint'($signed(b[15:0])))  <<< 16;
         2: p = longint'($signed(a)) * longint'($signed(b[31:16]));
         default: p = longint'($signed(a)) * longint'($signed(b[15:0]));
      endcase
      return p[55:0];
   endfunction

   function automatic logic [55:0] mround(logic [55:0] acc, int frac);
      longint v    = longint'($signed(acc));
      longint one  = 64'sd1;
      longint maxv = (one <<< 47) - (one <<< frac);
      longint minv = -(one <<< 47);
      v = v + (one <<< (frac - 1));
      if (v > maxv)      v = maxv;
      else if (v < minv) v = minv;
      else               v = v & ~((one <<< frac) - 1);
      return v[55:0];
   endfunction

   // ---- driver ----
   task automatic do_op(logic [3:0] op, logic [31:0] a, logic [31:0] b, string req);
      logic [55:0] t;
      in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
      if (op >= 4'd1 && op <= 4'd4)      exp_acc = mprod(op, a, b);
      else if (op >= 4'd5 && op <= 4'd8) exp_acc = exp_acc + mprod(op, a, b);
      else if (op == 4'd9)               exp_acc = mround(exp_acc, 32);
      else if (op == 4'd10)              exp_acc = mround(exp_acc, 16);
      else if (op == 4'd11) begin
         t = exp_acc << b[1:0];
         exp_q.push_back('{t[47:16], req});
      end
      @(negedge clk);
      chk(req, 64'(acc_val), 64'(exp_acc));
   endtask

   task automatic idle();
      in_valid = 1'b0; in_op = 4'd0;
      @(negedge clk);
   endtask

   task automatic mul32(logic [31:0] a, logic [31:0] b);
      longint p = longint'($signed(a)) * longint'($signed(b));
      exp_q.push_back('{p[31:0], "R8"});
      in_valid = 1'b1; in_op = 4'd12; in_a = a; in_b = b;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         chk("R8 busy", 64'(busy), 64'd1);
         chk("R9 ready low", 64'(in_ready), 64'd0);
         in_valid = (k < 2); in_op = 4'd6; in_a = 32'h0001_0001; in_b = 32'h0001_0001;
         @(negedge clk);
      end
      chk("R8 busy fell", 64'(busy), 64'd0);
      chk("R9 acc untouched", 64'(acc_val), 64'(exp_acc));
   endtask

   // ---- monitor ----
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         exp_t e;
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11 actual=res_valid data=%h expected=no result", res_data);
         end else begin
            e = exp_q.pop_front();
            chk(e.req, 64'(res_data), 64'(e.data));
         end
      end
   end

   // ---- watchdog ----
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 acc", 64'(acc_val), 64'd0);
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 ready", 64'(in_ready), 64'd1);
      chk("R1 res_valid", 64'(res_valid), 64'd0);

      // R2: each slicing, overwrite
      do_op(4'd1, 32'h0003_0005, 32'hFFFE_0007, "R2 hh");
      chk("R11 no result after mul", 64'(res_valid), 64'd0);
      do_op(4'd2, 32'h1234_8001, 32'h0000_7FFF, "R2 ll");
      do_op(4'd3, 32'h8000_0001, 32'h7FFF_0000, "R2 wh");
      do_op(4'd4, 32'hFFFF_FF00, 32'h0000_8000, "R2 wl");
      // R3 / R4: back-to-back accumulation in all slicings
      do_op(4'd5, 32'hFFFF_0000, 32'h0002_0000, "R3 hh");
      do_op(4'd6, 32'h0000_7FFF, 32'h0000_7FFF, "R3 ll");
      do_op(4'd7, 32'h1234_5678, 32'h8765_0000, "R4 wh");
      do_op(4'd8, 32'hDEAD_BEEF, 32'h0000_CAFE, "R4 wl");
      idle();
      // R10: NOP and unused opcodes
      do_op(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 nop");
      do_op(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 op13");
      do_op(4'd15, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R10 op15");
      idle();
      chk("R10 no result", 64'(res_valid), 64'd0);
      // R7: read-out at every shift amount
      for (int s = 0; s < 4; s++) do_op(4'd11, 32'h0, 32'(s), "R7 rdsh");
      idle();
      // R5 / R6: rounding without saturation
      do_op(4'd4, 32'h0000_8000, 32'h0000_0001, "R5 setup");
      do_op(4'd10, 32'h0, 32'h0, "R5 round up");
      do_op(4'd4, 32'hFFFF_8000, 32'h0000_0001, "R5 setup neg");
      do_op(4'd10, 32'h0, 32'h0, "R5 round neg half");
      do_op(4'd4, 32'h4000_0000, 32'h0000_0002, "R6 setup");
      do_op(4'd9, 32'h0, 32'h0, "R6 round up");
      do_op(4'd4, 32'h1234_5678, 32'h0000_1357, "R6 setup mid");
      do_op(4'd9, 32'h0, 32'h0, "R6 round mid");
      // positive saturation: 16 * 2^44 = 2^48
      do_op(4'd3, 32'h4000_0000, 32'h4000_0000, "R5 sat setup");
      for (int i = 0; i < 15; i++) do_op(4'd7, 32'h4000_0000, 32'h4000_0000, "R4 sat accum");
      do_op(4'd10, 32'h0, 32'h0, "R5 sat max");
      do_op(4'd9, 32'h0, 32'h0, "R6 sat max");
      // R3 wrap: 512 * 2^46 = 2^55 -> wraps to -2^55
      do_op(4'd3, 32'h8000_0000, 32'h8000_0000, "R3 wrap setup");
      for (int i = 0; i < 511; i++) do_op(4'd7, 32'h8000_0000, 32'h8000_0000, "R3 wrap accum");
      chk("R3 wrapped", 64'(acc_val), 64'h0080_0000_0000_0000);
      do_op(4'd9, 32'h0, 32'h0, "R6 sat min");
      chk("R6 min value", 64'(acc_val), 64'h00FF_8000_0000_0000);
      idle();
      // R8 / R9: 32x32 multiply
      do_op(4'd4, 32'h0012_3456, 32'h0000_0FED, "R8 acc setup");
      idle();
      mul32(32'hFFFF_FFF9, 32'd123456);
      mul32(32'h8000_0000, 32'h8000_0000);
      mul32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      mul32(32'h89AB_CDEF, 32'h7654_3210);
      idle();
      do_op(4'd11, 32'h0, 32'h1, "R7 after mul32");
      idle();
      repeat (3) idle();
      chk("R11 queue drained", 64'(exp_q.size()), 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule